// File: doc/BRIEF.md
# Tagged ADC result router

The block sits between an ADC result stream and a set of reaction channels. Each result is a 16-bit value with a 4-bit tag. It can come from a hardware ADC port, marked by a valid strobe, or from software, which writes the sensor input register over a small register bus. A software write takes priority over a hardware result in the same cycle.

A configuration register holds two router fields, each with its own write enable. A result whose tag equals an enabled router field is copied into the matching entry of a two-entry threshold bank. Every accepted result, from either source, also produces a one-cycle trigger that carries the tag as the index of the reaction channel that must run its comparison. The last accepted result and its tag can be read back through the sensor input register.

Top module: `tag_router`

## Requirements
- R1: An accepted result is a 16-bit value and a 4-bit tag. From hardware, it is accepted when `adc_valid` is high. From software, it is accepted when `reg_wr` is high with `reg_addr`=1, and `reg_wdata[15:0]` holds the value and `reg_wdata[19:16]` holds the tag.
- R2: When an accepted tag equals router field 0 (config bits [3:0]) and enable 0 (config bit 8) is set, threshold entry 0 (`thr0`) takes the value on the next clock edge.
- R3: When an accepted tag equals router field 1 (config bits [7:4]) and enable 1 (config bit 9) is set, threshold entry 1 (`thr1`) takes the value on the next clock edge.
- R4: While an entry's enable is clear, no result changes that entry, even when the tag matches.
- R5: When a software write and a hardware result arrive in the same cycle, only the software result is processed. The hardware result is dropped.
- R6: Each accepted result raises `trig_pulse` for exactly one cycle, in the cycle after acceptance, with `trig_chan` equal to the tag. A configuration write and an idle cycle raise no trigger.
- R7: After reset, the configuration register, both threshold entries and the sensor readback are zero. The configuration register is read with `reg_addr`=0, and its bits [31:10] always read zero.
- R8: When both router fields hold the accepted tag and both enables are set, both entries take the same value.
- R9: Reading with `reg_addr`=1 returns the last accepted value in bits [15:0] and its tag in bits [19:16], whichever source supplied it. The other bits read zero.
- R10: A result that arrives in the same cycle as a configuration write is routed using the configuration that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = configuration, 1 = sensor input |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| adc_valid | input | 1 | Hardware result strobe |
| adc_data | input | 16 | Hardware result value |
| adc_tag | input | 4 | Hardware result tag |
| thr0 | output | 16 | Threshold bank entry 0 |
| thr1 | output | 16 | Threshold bank entry 1 |
| trig_pulse | output | 1 | One-cycle reaction trigger |
| trig_chan | output | 4 | Index of the triggered reaction channel |

## Verification
The two events that can meet in one cycle are a software injection and a hardware result. A configuration write can also coincide with a hardware result. The bench drives a software write and a hardware strobe in the same cycle, with different tags and values, and expects the trigger channel, the threshold entries and the readback to reflect only the software result. It also drives a configuration write together with a hardware result and expects the routing to follow the old router fields.

// File: rtl/tag_router.sv
module tag_router #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [TAG_W-1:0]  adc_tag,
  output logic [DATA_W-1:0] thr0,
  output logic [DATA_W-1:0] thr1,
  output logic              trig_pulse,
  output logic [TAG_W-1:0]  trig_chan
);
  localparam int NENT   = 2;
  localparam int EN_LSB = 2 * TAG_W;
  localparam int CFG_W  = EN_LSB + NENT;

  logic [TAG_W-1:0]  route_q [NENT];
  logic [NENT-1:0]   wen_q;
  logic [DATA_W-1:0] thr_q   [NENT];
  logic [DATA_W-1:0] last_data;
  logic [TAG_W-1:0]  last_tag;

  logic              sw_wr, cfg_wr, accept;
  logic [DATA_W-1:0] in_data;
  logic [TAG_W-1:0]  in_tag;

  assign sw_wr   = reg_wr & reg_addr;
  assign cfg_wr  = reg_wr & ~reg_addr;
  assign accept  = sw_wr | adc_valid;
  assign in_data = sw_wr ? reg_wdata[DATA_W-1:0] : adc_data;
  assign in_tag  = sw_wr ? reg_wdata[DATA_W +: TAG_W] : adc_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q[0] <= '0;
      route_q[1] <= '0;
      wen_q      <= '0;
    end else if (cfg_wr) begin
      route_q[0] <= reg_wdata[TAG_W-1:0];
      route_q[1] <= reg_wdata[TAG_W +: TAG_W];
      wen_q      <= reg_wdata[EN_LSB +: NENT];
    end
  end

  for (genvar e = 0; e < NENT; e++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_q[e] <= '0;
      else if (accept && wen_q[e] && in_tag == route_q[e])
        thr_q[e] <= in_data;
    end
  end

  assign thr0 = thr_q[0];
  assign thr1 = thr_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_data  <= '0;
      last_tag   <= '0;
      trig_pulse <= 1'b0;
      trig_chan  <= '0;
    end else begin
      trig_pulse <= accept;
      if (accept) begin
        last_data <= in_data;
        last_tag  <= in_tag;
        trig_chan <= in_tag;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata[DATA_W-1:0]      = last_data;
      reg_rdata[DATA_W +: TAG_W] = last_tag;
    end else begin
      reg_rdata[TAG_W-1:0]       = route_q[0];
      reg_rdata[TAG_W +: TAG_W]  = route_q[1];
      reg_rdata[EN_LSB +: NENT]  = wen_q;
    end
  end
endmodule

module tag_router_chk #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [BUS_W-1:0]  reg_wdata,
  input logic [BUS_W-1:0]  reg_rdata,
  input logic              adc_valid,
  input logic [TAG_W-1:0]  adc_tag,
  input logic [DATA_W-1:0] thr0,
  input logic [DATA_W-1:0] thr1,
  input logic              trig_pulse,
  input logic [TAG_W-1:0]  trig_chan,
  input logic [1:0]        wen_q
);
  localparam int CFG_W = 2 * TAG_W + 2;
  logic sw;
  assign sw = reg_wr && reg_addr;

  assert_trig_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw || adc_valid) |=> trig_pulse &&
      trig_chan == $past(sw ? reg_wdata[DATA_W +: TAG_W] : adc_tag));

  assert_no_idle_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw || adc_valid) |=> !trig_pulse);

  assert_sw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw && adc_valid) |=> trig_chan == $past(reg_wdata[DATA_W +: TAG_W]));

  assert_hold_entry0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q[0] |=> $stable(thr0));

  assert_hold_entry1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q[1] |=> $stable(thr1));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> reg_rdata[BUS_W-1:CFG_W] == '0);
endmodule

bind tag_router tag_router_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_valid(adc_valid),
  .adc_tag(adc_tag), .thr0(thr0), .thr1(thr1), .trig_pulse(trig_pulse),
  .trig_chan(trig_chan), .wen_q(wen_q)
);

// File: tb/tag_router_tb.sv
module tag_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        adc_valid = 1'b0;
  logic [15:0] adc_data = '0;
  logic [3:0]  adc_tag = '0;
  logic [15:0] thr0, thr1;
  logic        trig_pulse;
  logic [3:0]  trig_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_router dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_valid(adc_valid),
    .adc_data(adc_data), .adc_tag(adc_tag), .thr0(thr0), .thr1(thr1),
    .trig_pulse(trig_pulse), .trig_chan(trig_chan)
  );

  typedef struct { logic [3:0] chan; logic [15:0] t0; logic [15:0] t1; } item_t;
  item_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0]  m_route [2];
  logic        m_en    [2];
  logic [15:0] m_thr   [2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock of stimulus: optional config write, software injection, hardware result
  task automatic step(input bit cw, input logic [31:0] cdata,
                      input bit sw, input logic [15:0] sv, input logic [3:0] st,
                      input bit hw, input logic [15:0] hv, input logic [3:0] ht);
    logic acc;
    logic [15:0] v;
    logic [3:0] t;
    @(negedge clk);
    reg_wr    = cw | sw;
    reg_addr  = sw;
    reg_wdata = sw ? {12'h0, st, sv} : cdata;
    adc_valid = hw; adc_data = hv; adc_tag = ht;
    acc = sw | hw;
    v = sw ? sv : hv;
    t = sw ? st : ht;
    @(posedge clk);
    if (acc) begin
      for (int e = 0; e < 2; e++)
        if (m_en[e] && m_route[e] == t) m_thr[e] = v;
      exp_q.push_back('{chan: t, t0: m_thr[0], t1: m_thr[1]});
    end
    if (cw && !sw) begin
      m_route[0] = cdata[3:0]; m_route[1] = cdata[7:4];
      m_en[0] = cdata[8]; m_en[1] = cdata[9];
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reg_wr = 1'b0; adc_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // monitor: every trigger must match the next expected item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && trig_pulse) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected trigger", {28'h0, trig_chan}, 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(trig_chan == it.chan, "R6 trigger channel", {28'h0, trig_chan}, {28'h0, it.chan});
          chk(thr0 == it.t0, "R2/R4 thr0 after result", {16'h0, thr0}, {16'h0, it.t0});
          chk(thr1 == it.t1, "R3/R4 thr1 after result", {16'h0, thr1}, {16'h0, it.t1});
        end
      end else if (rst_n && exp_q.size() != 0) begin
        chk(1'b0, "R6 missing trigger", 32'h0, {28'h0, exp_q[0].chan});
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < 2; e++) begin m_route[e] = '0; m_en[e] = 1'b0; m_thr[e] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd(1'b0, 32'h0, "R7 config reset");
    rd(1'b1, 32'h0, "R7 sensor reset");
    chk(thr0 == 16'h0 && thr1 == 16'h0, "R7 thresholds reset", {thr1, thr0}, 32'h0);
    chk(!trig_pulse, "R7 no trigger after reset", {31'h0, trig_pulse}, 32'h0);

    // R7 reserved bits dropped; R6 config write gives no trigger
    step(1, 32'hFFFF_F353, 0, 0, 0, 0, 0, 0);
    idle(2);
    rd(1'b0, 32'h0000_0353, "R7 reserved bits read zero");

    // R2 / R3 routing from hardware, R1 value/tag reception
    step(0, 0, 0, 0, 0, 1, 16'h1234, 4'd3);
    step(0, 0, 0, 0, 0, 1, 16'hBEEF, 4'd5);
    step(0, 0, 0, 0, 0, 1, 16'hCAFE, 4'd7);
    idle(2);
    chk(thr0 == 16'h1234, "R2 entry0 routed", {16'h0, thr0}, 32'h1234);
    chk(thr1 == 16'hBEEF, "R3 entry1 routed", {16'h0, thr1}, 32'hBEEF);
    rd(1'b1, 32'h0007_CAFE, "R9 R1 hardware result readback");

    // R4 disabled entry holds
    step(1, 32'h0000_0253, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'h5555, 4'd3);
    idle(2);
    chk(thr0 == 16'h1234, "R4 disabled entry0 unchanged", {16'h0, thr0}, 32'h1234);

    // R5 software wins over simultaneous hardware
    step(0, 0, 1, 16'h0A0A, 4'd5, 1, 16'h7777, 4'd3);
    idle(2);
    chk(thr1 == 16'h0A0A, "R5 software value routed", {16'h0, thr1}, 32'h0A0A);
    rd(1'b1, 32'h0005_0A0A, "R5 R9 software readback");

    // R8 both entries on one tag
    step(1, 32'h0000_0399, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16'h4242, 4'd9, 0, 0, 0);
    idle(2);
    chk(thr0 == 16'h4242 && thr1 == 16'h4242, "R8 both entries", {thr1, thr0}, 32'h4242_4242);

    // R10 config write alongside hardware result uses old config
    step(1, 32'h0000_0192, 0, 0, 0, 1, 16'h1111, 4'd9);
    idle(2);
    chk(thr0 == 16'h1111 && thr1 == 16'h1111, "R10 old config routes", {thr1, thr0}, 32'h1111_1111);
    step(0, 0, 0, 0, 0, 1, 16'h2222, 4'd2);
    step(0, 0, 0, 0, 0, 1, 16'h3333, 4'd9);
    idle(2);
    chk(thr0 == 16'h2222, "R10 new config routes", {16'h0, thr0}, 32'h2222);
    chk(thr1 == 16'h1111, "R4 entry1 disabled by new config", {16'h0, thr1}, 32'h1111);

    // R6 back-to-back results, mixed sources
    step(0, 0, 1, 16'hAAAA, 4'd1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'hBBBB, 4'd2);
    step(0, 0, 1, 16'hCCCC, 4'd15, 0, 0, 0);
    idle(3);
    chk(exp_q.size() == 0, "R6 all triggers seen", exp_q.size(), 32'h0);
    rd(1'b1, 32'h000F_CCCC, "R9 last of burst");
    chk(thr0 == 16'hBBBB, "R2 burst entry0", {16'h0, thr0}, 32'hBBBB);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule